// File: doc/BRIEF.md
# Radix-2 Booth Sequential Signed Multiplier

This block multiplies two signed two's-complement operands of `N` bits (default 4) over several clock cycles and returns their full `2N`-bit signed product. A single-cycle `start_i` pulse captures both operands. The block then runs exactly `N` iterations and reports completion with a one-cycle `done_o` pulse.

Each iteration looks at two bits: the lowest bit of the working multiplier, and the bit that the previous iteration shifted out (a zero before the first iteration). From that pair it adds the multiplicand into an accumulator, subtracts the multiplicand from it, or leaves it unchanged. It then shifts accumulator, multiplier and the shifted-out bit right by one place as a single signed quantity. The accumulator carries one extra guard bit, so the most negative multiplicand is handled exactly.

The product stays on `product_o` until the next accepted start. A start request that arrives while a multiplication is running has no effect.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset (`rst_n` low) is asserted and in the first cycle after it, `busy_o` and `done_o` are 0 and `product_o` is 0. A reset during a multiplication abandons it.
- R2: A `start_i` sampled high while `busy_o` is low makes `busy_o` high from the next cycle, for exactly `N` consecutive cycles.
- R3: `done_o` is high for exactly one cycle, namely the first cycle in which `busy_o` is low again after a run. Otherwise it is low.
- R4: When `done_o` is high, `product_o` (bit 2N-1 is the sign bit) equals the signed product of the captured multiplicand and multiplier, for every operand pair.
- R5: Each iteration adds the multiplicand when the (current low bit, previous shifted-out bit) pair is (0,1), subtracts it when the pair is (1,0), and does neither for (0,0) or (1,1). Multipliers of all zeros, all ones and alternating bits therefore give correct products.
- R6: A multiplicand of -2^(N-1) gives the correct product with any multiplier, including -2^(N-1) times -2^(N-1) = +2^(2N-2).
- R7: While `busy_o` is low and `start_i` is low, `product_o` does not change, whatever the operand inputs do.
- R8: A `start_i` pulse while `busy_o` is high is ignored: the run length and the result are those of the operands already captured.
- R9: Operand inputs are sampled only in the accepting start cycle. Changing them during a run does not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to capture operands and begin a multiplication |
| multiplicand_i | input | N | Signed multiplicand |
| multiplier_i | input | N | Signed multiplier |
| busy_o | output | 1 | High while iterations are in progress |
| done_o | output | 1 | One-cycle pulse when the product becomes valid |
| product_o | output | 2N | Signed product, held until the next accepted start |

## Verification
A wrong add/subtract decision, or a shift that loses the sign, does not stay hidden in the accumulator. It shifts into the low half of the product and shows at `product_o` in the `done_o` cycle, `N` cycles after the start. The exhaustive operand sweep therefore exposes any recoding or sign-extension fault within one run. A counter fault shows at once as a wrong `busy_o` length or a missing or stretched `done_o` pulse. Operand scrambling during every run and stray start pulses mid-run expose inputs that are sampled when they should not be.

// File: rtl/booth_pkg.sv
`timescale 1ns/1ps
package booth_pkg;
    // Action chosen by the recoder for one iteration
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;
endpackage

// File: rtl/booth_recoder.sv
`timescale 1ns/1ps
module booth_recoder
    import booth_pkg::*;
(
    input  logic      cur_bit_i,
    input  logic      prev_bit_i,
    output booth_op_e op_o
);
    // R5: (0,1) start of a run of ones ends -> add; (1,0) run begins -> subtract
    always_comb begin
        case ({cur_bit_i, prev_bit_i})
            2'b01:   op_o = OP_ADD;
            2'b10:   op_o = OP_SUB;
            default: op_o = OP_NONE;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
`timescale 1ns/1ps
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 5
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] mcd_i,
    input  booth_op_e    op_i,
    output logic [W-1:0] acc_o
);
    logic [W-1:0] operand;
    logic         carry_in;

    // Subtraction adds the inverted operand with a carry-in of one;
    // the carry out of the top bit is dropped by the W-bit sum.
    always_comb begin
        case (op_i)
            OP_ADD: begin
                operand  = mcd_i;
                carry_in = 1'b0;
            end
            OP_SUB: begin
                operand  = ~mcd_i;
                carry_in = 1'b1;
            end
            default: begin
                operand  = '0;
                carry_in = 1'b0;
            end
        endcase
        acc_o = acc_i + operand + W'(carry_in);
    end
endmodule

// File: rtl/booth_asr.sv
`timescale 1ns/1ps
module booth_asr #(
    parameter int AW = 5,
    parameter int QW = 4
) (
    input  logic [AW-1:0] acc_i,
    input  logic [QW-1:0] q_i,
    output logic [AW-1:0] acc_o,
    output logic [QW-1:0] q_o,
    output logic          qm1_o
);
    // Sign-preserving right shift of the joined accumulator/multiplier/extra bit
    always_comb begin
        {acc_o, q_o, qm1_o} = {acc_i[AW-1], acc_i, q_i};
    end
endmodule

// File: rtl/booth_seq_mult.sv
`timescale 1ns/1ps
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [N-1:0]     multiplicand_i,
    input  logic [N-1:0]     multiplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [2*N-1:0]   product_o
);
    localparam int AW = N + 1;              // guard bit for -2^(N-1)
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(N);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [AW-1:0] acc;
        logic [N-1:0]  mlr;
        logic          qm1;
        logic [AW-1:0] mcd;
    } state_t;

    state_t state_d, state_q;

    booth_op_e     step_op;
    logic [AW-1:0] acc_sum;
    logic [AW-1:0] acc_shr;
    logic [N-1:0]  mlr_shr;
    logic          qm1_shr;

    booth_recoder u_recoder (
        .cur_bit_i  (state_q.mlr[0]),
        .prev_bit_i (state_q.qm1),
        .op_o       (step_op)
    );

    booth_addsub #(.W(AW)) u_addsub (
        .acc_i (state_q.acc),
        .mcd_i (state_q.mcd),
        .op_i  (step_op),
        .acc_o (acc_sum)
    );

    booth_asr #(.AW(AW), .QW(N)) u_asr (
        .acc_i (acc_sum),
        .q_i   (state_q.mlr),
        .acc_o (acc_shr),
        .q_o   (mlr_shr),
        .qm1_o (qm1_shr)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (!state_q.busy) begin
            if (start_i) begin
                state_d.busy = 1'b1;
                state_d.cnt  = CNT_LOAD;
                state_d.acc  = '0;
                state_d.mlr  = multiplier_i;
                state_d.qm1  = 1'b0;
                state_d.mcd  = {multiplicand_i[N-1], multiplicand_i};
            end
        end else begin
            state_d.acc = acc_shr;
            state_d.mlr = mlr_shr;
            state_d.qm1 = qm1_shr;
            state_d.cnt = state_q.cnt - CNT_LAST;
            if (state_q.cnt == CNT_LAST) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o    = state_q.busy;
    assign done_o    = state_q.done;
    assign product_o = {state_q.acc[N-1:0], state_q.mlr};

    // R2: accepted start leads to busy
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R2: counter stays in its legal window while running
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (state_q.cnt != '0 && state_q.cnt <= CNT_LOAD));

    // R2: not the last step, so still busy next cycle
    p_run_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q.cnt != CNT_LAST) |=> busy_o);

    // R3: last step ends the run with a done pulse
    p_last_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q.cnt == CNT_LAST) |=> (done_o && !busy_o));

    // R3: done never lasts two cycles
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: idle without start keeps the product
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));

    // R8: start while running does not reload the counter
    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q.cnt != CNT_LAST)
            |=> (state_q.cnt == $past(state_q.cnt) - CNT_LAST));
endmodule

// File: tb/booth_seq_mult_tb_top.sv
`timescale 1ns/1ps
module booth_seq_mult_tb_top;
    localparam int N  = 4;
    localparam int PW = 2 * N;
    localparam int NV = 10;

    // {multiplicand, multiplier, expected product}
    localparam logic [15:0] VEC [NV] = '{
        {4'h7, 4'h3, 8'h15},   // +7 * +3  = +21
        {4'h7, 4'hD, 8'hEB},   // +7 * -3  = -21
        {4'h0, 4'h5, 8'h00},   // zero multiplicand
        {4'h8, 4'h8, 8'h40},   // R6: -8 * -8 = +64
        {4'h8, 4'h7, 8'hC8},   // R6: -8 * +7 = -56
        {4'h7, 4'h8, 8'hC8},   // +7 * -8
        {4'hF, 4'hF, 8'h01},   // R5: all-ones multiplier
        {4'h5, 4'h5, 8'h19},   // R5: alternating multiplier
        {4'hD, 4'h6, 8'hEE},   // -3 * +6
        {4'h6, 4'hF, 8'hFA}    // +6 * -1
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   mcd = '0;
    logic [N-1:0]   mlr = '0;
    logic           busy;
    logic           done;
    logic [PW-1:0]  prod;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    booth_seq_mult #(.N(N)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .multiplicand_i (mcd),
        .multiplier_i   (mlr),
        .busy_o         (busy),
        .done_o         (done),
        .product_o      (prod)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic signed [PW-1:0] sa, sb, r;
        sa = {{N{a[N-1]}}, a};
        sb = {{N{b[N-1]}}, b};
        r  = sa * sb;
        return r;
    endfunction

    // Start a run, scramble operands afterwards (R9), check length, pulse, result
    task automatic run_one(input logic [N-1:0] a, input logic [N-1:0] b,
                           input logic [PW-1:0] exp, input string req);
        int cycles;
        @(negedge clk);
        mcd = a; mlr = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0; mcd = ~a; mlr = b ^ 4'h6;
        cycles = 0;
        while (busy && cycles < 4 * N) begin
            cycles++;
            @(negedge clk);
        end
        chk(cycles == N, "R2", "busy length", cycles, N);
        chk(done == 1'b1, "R3", "done at end", done, 1);
        chk(prod == exp, req, "product (R4/R9)", prod, exp);
        @(negedge clk);
        chk(done == 1'b0, "R3", "done single", done, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(prod == '0, "R1", "product in reset", prod, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && prod == '0, "R1", "after reset",
            {busy, done, prod}, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            run_one(VEC[i][15:12], VEC[i][11:8], VEC[i][7:0], "R4");
        end

        // R5: recoding patterns
        run_one(4'h3, 4'h0, 8'h00, "R5");
        run_one(4'h3, 4'hF, 8'hFD, "R5");
        run_one(4'hB, 4'hA, 8'h1E, "R5");   // -5 * -6 = +30

        // R7: hold while idle with moving operands
        begin
            logic [PW-1:0] held;
            held = prod;
            for (int k = 0; k < 6; k++) begin
                mcd = 4'(k * 3); mlr = 4'(k * 5 + 1);
                @(negedge clk);
                chk(prod == held, "R7", "held product", prod, held);
                chk(done == 1'b0 && busy == 1'b0, "R7", "idle flags", {busy, done}, 0);
            end
        end

        // R8: start pulse mid-run ignored
        begin
            int cycles;
            @(negedge clk);
            mcd = 4'h7; mlr = 4'h3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cycles = 1;
            @(negedge clk);
            mcd = 4'h5; mlr = 4'h5; start = 1'b1;
            cycles++;
            @(negedge clk);
            start = 1'b0;
            while (busy && cycles < 4 * N) begin
                cycles++;
                @(negedge clk);
            end
            chk(cycles == N, "R8", "run length with stray start", cycles, N);
            chk(prod == 8'h15, "R8", "result with stray start", prod, 8'h15);
            @(negedge clk);
        end

        // R1: reset during a run
        @(negedge clk);
        mcd = 4'h6; mlr = 4'h6; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(busy == 1'b0 && prod == '0, "R1", "reset mid-run", {busy, prod}, 0);
        @(negedge clk);
        chk(done == 1'b0, "R1", "no done after abandon", done, 0);

        // R4/R6: exhaustive sweep
        for (int i = 0; i < (1 << N); i++) begin
            for (int j = 0; j < (1 << N); j++) begin
                run_one(i[N-1:0], j[N-1:0], ref_mul(i[N-1:0], j[N-1:0]),
                        (i == (1 << (N - 1))) ? "R6" : "R4");
            end
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule